// File: doc/BRIEF.md
# Multi-Function Card Interrupt Aggregator

This block gathers the interrupt requests of a three-function add-in card and presents them on a single card interrupt output. Function 0 combines two sources. One is a request from the on-card DSP. The other is the falling edge of a ring-detect input. Functions 1 and 2 each take one request pin from outside the chip. For each function the host can read and write a two-bit status word. Bit 0 selects the clearing policy and bit 1 is the pending flag.

Two clearing policies exist, and one selected policy applies to the whole card. While every policy bit is 0, a request is cleared where it originates. The DSP drops its line, the external pin goes low, or the ring source acknowledges. Once any one policy bit is 1, every function latches its request on an edge, and the host clears it by writing 0 to the pending flag. A mode input picks the output path. In card-bus mode, enabled functions drive an active-low shared request line. In ISA mode, the combined request goes out on the one IRQ line chosen by a one-hot select.

Top module: `mfc_irq_agg`

## Requirements
- R1: After reset, all pending flags read 0, all policy bits read 0, `ireq_n` is 1 and every `isa_irq` line is 0.
- R2: A host write to function i (`csr_wr[i]`) stores `csr_wdata[0]` as its policy bit. `pol_rd[i]` returns exactly that value, whatever the other functions hold.
- R3: If any one policy bit is 1, all three functions use clear-by-write behaviour, including functions whose own bit is 0.
- R4: While all policy bits are 0, an external function's pending flag follows its request pin after two synchronizer stages. A host write of 0 to its pending flag (`csr_wdata[1]`) has no effect.
- R5: While clear-by-write is active, a rising edge on an external request pin sets that function's pending flag. The flag stays set after the pin falls, survives a write of 1, and clears on a host write of 0.
- R6: A falling edge on `ring_n` (synchronized) sets the function 0 pending flag. Under clear-at-source it clears on a `ring_ack` pulse, and host writes do not clear it. Under clear-by-write, `ring_ack` has no effect and a host write of 0 clears it.
- R7: Under clear-at-source, function 0 pending follows `dsp_req` directly. Under clear-by-write, a rising edge of `dsp_req` is latched. A single host write of 0 to function 0 clears both the DSP and the ring latches.
- R8: Pending flags read back their state whatever the output-enable bits hold.
- R9: In card-bus mode (`isa_mode`=0), `ireq_n` is 0 exactly when some function is both pending and output-enabled (`out_en[i]`=1).
- R10: In ISA mode, `ireq_n` stays 1 and `out_en` is ignored. Function 0 is enabled by `pnp_active`, and functions 1 and 2 are forced disabled.
- R11: In ISA mode, the OR of all pending flags drives only the line selected by `irq_sel`. If `irq_sel` has more than one bit set, all `isa_irq` lines stay 0.
- R12: In card-bus mode, all `isa_irq` lines are 0.
- R13: A disabled function captures nothing and its pending flag reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| isa_mode | input | 1 | 1 = ISA routing, 0 = card-bus routing |
| func_en | input | 3 | Card-bus function enables |
| pnp_active | input | 1 | ISA-mode enable for function 0 |
| out_en | input | 3 | Per-function card-bus output enables |
| irq_sel | input | 9 | One-hot ISA IRQ line select |
| dsp_req | input | 1 | DSP request level, synchronous |
| ring_ack | input | 1 | Source acknowledge for ring event (pulse) |
| ring_n | input | 1 | Asynchronous ring-detect input, active falling edge |
| ext_req | input | 2 | Asynchronous requests of functions 1 and 2 |
| csr_wr | input | 3 | Per-function status write strobe |
| csr_wdata | input | 2 | Status write data: bit 0 policy, bit 1 pending |
| pol_rd | output | 3 | Policy bit readback per function |
| pend_rd | output | 3 | Pending flag readback per function |
| ireq_n | output | 1 | Shared card-bus request, active low |
| isa_irq | output | 9 | ISA IRQ lines |

## Verification
The hardest case to reach is a function whose own policy bit is 0 that must still behave under clear-by-write. Reaching it requires setting only another function's policy bit and then pulsing this function's pin, so that a flag which survives the pin's fall can only come from the global policy. The same pattern is used to show that one host write clears both function 0 sources. The bench latches a ring edge and a DSP edge, checks that `ring_ack` leaves the flag set, and then issues a single write. The ISA path is reached by changing mode with requests still active, so that the forced-off enables and a select with two bits set are each observed at the outputs.

// File: rtl/mfc_irq_pkg.sv
// Package: shared constants and types for the interrupt aggregator.
// Assumes: status word layout is fixed (policy at bit 0, pending at bit 1).
package mfc_irq_pkg;
    localparam int STAT_W   = 2;
    localparam int POL_BIT  = 0;
    localparam int PEND_BIT = 1;

    typedef enum logic {
        CLR_AT_SOURCE = 1'b0,
        CLR_BY_WRITE  = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/mfc_sync.sv
// Multi-stage synchronizer for asynchronous request pins.
// Assumes: each bit is an independent level; STAGES >= 2.
module mfc_sync #(
    parameter int WIDTH   = 1,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= {WIDTH{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mfc_evt_flag.sv
// Edge-latched event flag with hold, set and clear.
// Priority: hold (forces 0) over a detected edge (sets) over clear.
// Assumes: lvl is synchronous to clk.
module mfc_evt_flag #(
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic hold,
    input  logic clr,
    output logic flag
);
    logic prev_q;
    logic edge_hit;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= FALL_EDGE;
        else        prev_q <= lvl;
    end

    // Decode the configured edge direction.
    always_comb begin
        if (FALL_EDGE) edge_hit = prev_q & ~lvl;
        else           edge_hit = lvl & ~prev_q;
    end

    // Update the latched flag under hold/set/clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hold)     flag <= 1'b0;
        else if (edge_hit) flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end
endmodule

// File: rtl/mfc_irq_route.sv
// Routes the per-function pending flags to the card-bus line or an ISA line.
// Assumes: pend is already gated by the function enables.
module mfc_irq_route #(
    parameter int NUM_FUNC = 3,
    parameter int NUM_IRQ  = 9
) (
    input  logic                isa_mode,
    input  logic [NUM_FUNC-1:0] pend,
    input  logic [NUM_FUNC-1:0] out_en,
    input  logic [NUM_IRQ-1:0]  irq_sel,
    output logic                ireq_n,
    output logic [NUM_IRQ-1:0]  isa_irq
);
    logic any_pend;
    logic sel_ok;

    // Combine the pending flags and validate the one-hot select.
    always_comb begin
        any_pend = |pend;
        sel_ok   = ((irq_sel & (irq_sel - NUM_IRQ'(1))) == '0);
    end

    // Drive exactly one path depending on mode.
    always_comb begin
        if (isa_mode) begin
            ireq_n  = 1'b1;
            isa_irq = (any_pend && sel_ok) ? irq_sel : '0;
        end else begin
            ireq_n  = ~|(pend & out_en);
            isa_irq = '0;
        end
    end
endmodule

// File: rtl/mfc_irq_agg.sv
// Top: three-function interrupt aggregator.
// Function 0 = DSP level + ring falling edge; functions 1..N-1 = external pins.
// Assumes: dsp_req, ring_ack, host strobes are synchronous; ring_n/ext_req async.
module mfc_irq_agg
    import mfc_irq_pkg::*;
#(
    parameter int NUM_FUNC    = 3,
    parameter int NUM_IRQ     = 9,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_EXT    = NUM_FUNC - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                isa_mode,
    input  logic [NUM_FUNC-1:0] func_en,
    input  logic                pnp_active,
    input  logic [NUM_FUNC-1:0] out_en,
    input  logic [NUM_IRQ-1:0]  irq_sel,
    input  logic                dsp_req,
    input  logic                ring_ack,
    input  logic                ring_n,
    input  logic [NUM_EXT-1:0]  ext_req,
    input  logic [NUM_FUNC-1:0] csr_wr,
    input  logic [STAT_W-1:0]   csr_wdata,
    output logic [NUM_FUNC-1:0] pol_rd,
    output logic [NUM_FUNC-1:0] pend_rd,
    output logic                ireq_n,
    output logic [NUM_IRQ-1:0]  isa_irq
);
    logic [NUM_FUNC-1:0] pol_q;
    logic [NUM_FUNC-1:0] fen_eff;
    logic [NUM_FUNC-1:0] host_clr;
    logic [NUM_FUNC-1:0] pend;
    logic [NUM_EXT-1:0]  ext_s;
    logic                ring_s;
    logic                ring_flag;
    logic                dsp_flag;
    clr_mode_e           mode;

    // Store each function's policy bit on its host write.
    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= '0;
        else begin
            for (int i = 0; i < NUM_FUNC; i++)
                if (csr_wr[i]) pol_q[i] <= csr_wdata[POL_BIT];
        end
    end

    // One set policy bit switches the whole card to clear-by-write.
    always_comb begin
        mode = clr_mode_e'(|pol_q);
        for (int i = 0; i < NUM_FUNC; i++)
            host_clr[i] = csr_wr[i] & ~csr_wdata[PEND_BIT] & (mode == CLR_BY_WRITE);
    end

    // Effective enables: ISA mode keeps only function 0, gated by pnp_active.
    always_comb begin
        fen_eff[0] = isa_mode ? pnp_active : func_en[0];
        for (int i = 1; i < NUM_FUNC; i++)
            fen_eff[i] = isa_mode ? 1'b0 : func_en[i];
    end

    // Ring input synchronizer (idles high).
    mfc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ring_sync (
        .clk(clk), .rst_n(rst_n), .d(ring_n), .q(ring_s)
    );

    // External request synchronizers.
    mfc_sync #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_req), .q(ext_s)
    );

    // Ring event latch: source ack clears under one policy, host write under the other.
    mfc_evt_flag #(.FALL_EDGE(1'b1)) u_ring_flag (
        .clk(clk), .rst_n(rst_n), .lvl(ring_s), .hold(~fen_eff[0]),
        .clr((mode == CLR_BY_WRITE) ? host_clr[0] : ring_ack),
        .flag(ring_flag)
    );

    // DSP event latch, used only under clear-by-write.
    mfc_evt_flag #(.FALL_EDGE(1'b0)) u_dsp_flag (
        .clk(clk), .rst_n(rst_n), .lvl(dsp_req),
        .hold(~fen_eff[0] | (mode == CLR_AT_SOURCE)),
        .clr(host_clr[0]), .flag(dsp_flag)
    );

    // Function 0 pending: DSP level or latch, merged with the ring latch.
    always_comb begin
        if (mode == CLR_BY_WRITE) pend[0] = dsp_flag | ring_flag;
        else                      pend[0] = (dsp_req & fen_eff[0]) | ring_flag;
    end

    // External functions: level under clear-at-source, edge latch otherwise.
    for (genvar gi = 1; gi < NUM_FUNC; gi++) begin : g_ext
        logic ext_flag;

        mfc_evt_flag #(.FALL_EDGE(1'b0)) u_ext_flag (
            .clk(clk), .rst_n(rst_n), .lvl(ext_s[gi-1]),
            .hold(~fen_eff[gi] | (mode == CLR_AT_SOURCE)),
            .clr(host_clr[gi]), .flag(ext_flag)
        );

        // Select the pending source by policy.
        always_comb begin
            if (mode == CLR_BY_WRITE) pend[gi] = ext_flag;
            else                      pend[gi] = ext_s[gi-1] & fen_eff[gi];
        end
    end

    // Output routing.
    mfc_irq_route #(.NUM_FUNC(NUM_FUNC), .NUM_IRQ(NUM_IRQ)) u_route (
        .isa_mode(isa_mode), .pend(pend), .out_en(out_en), .irq_sel(irq_sel),
        .ireq_n(ireq_n), .isa_irq(isa_irq)
    );

    assign pol_rd  = pol_q;
    assign pend_rd = pend;
endmodule

// File: rtl/mfc_irq_agg_chk.sv
// Checker: temporal properties of the aggregator's ports, bound to the top.
module mfc_irq_agg_chk #(
    parameter int NUM_FUNC = 3,
    parameter int NUM_IRQ  = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                isa_mode,
    input logic [NUM_FUNC-1:0] out_en,
    input logic [NUM_FUNC-1:0] csr_wr,
    input logic [1:0]          csr_wdata,
    input logic [NUM_FUNC-1:0] pol_rd,
    input logic [NUM_FUNC-1:0] pend_rd,
    input logic                ireq_n,
    input logic [NUM_IRQ-1:0]  isa_irq
);
    // R2
    for (genvar gi = 0; gi < NUM_FUNC; gi++) begin : g_pol
        pol_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
            csr_wr[gi] |=> (pol_rd[gi] == $past(csr_wdata[0])));
    end

    // R9
    card_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!isa_mode && ((pend_rd & out_en) != '0)) |-> !ireq_n);

    // R9
    card_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!isa_mode && ((pend_rd & out_en) == '0)) |-> ireq_n);

    // R10
    isa_ireq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_mode |-> ireq_n);

    // R11
    isa_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isa_irq));

    // R12
    card_no_isa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_mode |-> (isa_irq == '0));
endmodule

bind mfc_irq_agg mfc_irq_agg_chk #(.NUM_FUNC(NUM_FUNC), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .isa_mode(isa_mode), .out_en(out_en),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .pol_rd(pol_rd), .pend_rd(pend_rd),
    .ireq_n(ireq_n), .isa_irq(isa_irq)
);

// File: tb/mfc_irq_agg_tb.sv
`timescale 1ns/100ps
module mfc_irq_agg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       isa_mode = 1'b0;
    logic [2:0] func_en = 3'b111;
    logic       pnp_active = 1'b0;
    logic [2:0] out_en = 3'b000;
    logic [8:0] irq_sel = '0;
    logic       dsp_req = 1'b0;
    logic       ring_ack = 1'b0;
    logic       ring_n = 1'b1;
    logic [1:0] ext_req = '0;
    logic [2:0] csr_wr = '0;
    logic [1:0] csr_wdata = '0;
    logic [2:0] pol_rd;
    logic [2:0] pend_rd;
    logic       ireq_n;
    logic [8:0] isa_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string       req;
        logic [15:0] mask;
        logic [15:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    mfc_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .isa_mode(isa_mode), .func_en(func_en),
        .pnp_active(pnp_active), .out_en(out_en), .irq_sel(irq_sel),
        .dsp_req(dsp_req), .ring_ack(ring_ack), .ring_n(ring_n), .ext_req(ext_req),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .pol_rd(pol_rd), .pend_rd(pend_rd),
        .ireq_n(ireq_n), .isa_irq(isa_irq)
    );

    // Monitor: pop expected items and compare with the observed outputs.
    initial begin
        forever begin
            item_t it;
            logic [15:0] obs;
            wait (sb_q.size() > 0);
            it  = sb_q.pop_front();
            obs = {ireq_n, isa_irq, pend_rd, pol_rd};
            n_vec++;
            if ((obs & it.mask) != (it.exp & it.mask)) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.req, obs & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic push(input string req, input logic [15:0] mask, input logic [15:0] exp);
        #0.1;
        sb_q.push_back('{req, mask, exp});
        wait (sb_q.size() == 0);
    endtask

    task automatic chk_pend(input string req, input logic [2:0] v);
        push(req, 16'h0038, {10'b0, v, 3'b0});
    endtask
    task automatic chk_pol(input string req, input logic [2:0] v);
        push(req, 16'h0007, {13'b0, v});
    endtask
    task automatic chk_ireq(input string req, input logic v);
        push(req, 16'h8000, {v, 15'b0});
    endtask
    task automatic chk_isa(input string req, input logic [8:0] v);
        push(req, 16'h7FC0, {1'b0, v, 6'b0});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [2:0] wr, input logic [1:0] d);
        csr_wr = wr; csr_wdata = d;
        tick(1);
        csr_wr = '0; csr_wdata = '0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    // Driver.
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk_pend("R1 pend", 3'b000);
        chk_pol("R1 pol", 3'b000);
        chk_ireq("R1 ireq_n", 1'b1);
        chk_isa("R1/R12 isa", 9'h000);

        // R4 level-following under clear-at-source, R8 readable with out_en off
        ext_req[0] = 1'b1; tick(4);
        chk_pend("R4/R8 level f1", 3'b010);
        chk_ireq("R8 ireq_n with out_en off", 1'b1);
        host_wr(3'b010, 2'b00); tick(1);
        chk_pend("R4 write0 no effect", 3'b010);
        ext_req[0] = 1'b0; tick(4);
        chk_pend("R4 level drop", 3'b000);

        // R9 card output, R13 disabled function
        out_en = 3'b010; ext_req[0] = 1'b1; tick(4);
        chk_ireq("R9 ireq_n asserted", 1'b0);
        chk_isa("R12 isa idle in card mode", 9'h000);
        func_en[1] = 1'b0; tick(2);
        chk_pend("R13 disabled f1", 3'b000);
        chk_ireq("R13/R9 ireq_n idle", 1'b1);
        func_en[1] = 1'b1; ext_req[0] = 1'b0; tick(4);

        // R2 policy readback, R3 global clear-by-write
        host_wr(3'b100, 2'b01); tick(1);
        chk_pol("R2 pol f2 only", 3'b100);
        ext_req[0] = 1'b1; tick(4);
        ext_req[0] = 1'b0; tick(4);
        chk_pend("R3/R5 f1 latched after pin drop", 3'b010);
        chk_ireq("R9 ireq_n from latch", 1'b0);
        host_wr(3'b010, 2'b10); tick(1);
        chk_pend("R5 write1 keeps flag", 3'b010);
        host_wr(3'b010, 2'b00); tick(1);
        chk_pend("R5 write0 clears", 3'b000);
        chk_pol("R2 pol unchanged", 3'b100);

        // R6/R7 function 0 under clear-by-write
        ring_n = 1'b0; tick(4); ring_n = 1'b1; tick(4);
        chk_pend("R6 ring latched", 3'b001);
        ring_ack = 1'b1; tick(1); ring_ack = 1'b0; tick(1);
        chk_pend("R6 ring_ack ignored", 3'b001);
        dsp_req = 1'b1; tick(2); dsp_req = 1'b0; tick(2);
        chk_pend("R7 dsp latched", 3'b001);
        host_wr(3'b001, 2'b00); tick(2);
        chk_pend("R7 single write clears dsp and ring", 3'b000);

        // R6/R7 function 0 under clear-at-source
        host_wr(3'b100, 2'b00); tick(1);
        chk_pol("R2 pol cleared", 3'b000);
        dsp_req = 1'b1; tick(1);
        chk_pend("R7 dsp level", 3'b001);
        dsp_req = 1'b0; tick(1);
        chk_pend("R7 dsp drop", 3'b000);
        ring_n = 1'b0; tick(4); ring_n = 1'b1; tick(4);
        chk_pend("R6 ring latched at source mode", 3'b001);
        host_wr(3'b001, 2'b00); tick(1);
        chk_pend("R6 write0 no effect", 3'b001);
        ring_ack = 1'b1; tick(1); ring_ack = 1'b0; tick(1);
        chk_pend("R6 ring_ack clears", 3'b000);

        // R10/R11 ISA routing
        isa_mode = 1'b1; pnp_active = 1'b1; irq_sel = 9'b000010000; out_en = 3'b111;
        ext_req[1] = 1'b1; tick(4);
        chk_pend("R10 f2 forced off", 3'b000);
        chk_isa("R11 no pending no line", 9'h000);
        dsp_req = 1'b1; tick(1);
        chk_isa("R11 selected line", 9'b000010000);
        chk_ireq("R10 ireq_n idle in ISA", 1'b1);
        irq_sel = 9'b100000001; tick(1);
        chk_isa("R11 two-bit select blocked", 9'h000);
        irq_sel = 9'b000000100; pnp_active = 1'b0; tick(1);
        chk_pend("R10 pnp inactive", 3'b000);
        chk_isa("R10 no line when inactive", 9'h000);

        // Back to card mode with two sources.
        isa_mode = 1'b0; out_en = 3'b001; tick(1);
        chk_pend("R9 f0 and f2 pending", 3'b101);
        chk_ireq("R9 ireq_n asserted f0", 1'b0);
        chk_isa("R12 isa idle", 9'h000);

        done = 1'b1;
        tick(2);
        summary();
    end
endmodule